// File: doc/BRIEF.md
# Two-Sample Input Debounce Filter

This block cleans up a vector of external input lines before they reach edge or level detection. Each line has a polarity setting. A line set for low-active or falling-edge use is inverted first, so one filter serves both polarities and its output is always high-active. The filter runs on its own slow debounce clock, which has no fixed phase relation to the bus clock. A level reaches the filter output only after two consecutive rising edges of that clock sample the same value. A shorter disturbance never gets through.

Each line also has a runtime enable. When the enable is off, the line bypasses the filter and the normalised raw level appears at the output with no clocked delay. The filters are off unless the enable is driven high. The filter flops have an asynchronous clear. The reset input is synchronised inside the block, so the clear is applied at once but is released only on debounce-clock edges. Moving the result into the interrupt clock domain is left to the detector downstream.

Top module: `pin_debounce_filter`

## Requirements
- R1: The normalised level of a line equals the input pin when its polarity bit is 1 (high-active) and the inverted pin when its polarity bit is 0 (low-active).
- R2: A line whose enable bit is 0 drives the output with its normalised level, combinationally, with no debounce-clock delay.
- R3: On a line whose enable bit is 1, a normalised level held across two consecutive debounce-clock rising edges appears at the output just after the second of those edges. The filter therefore adds two debounce-clock cycles of latency.
- R4: On an enabled line, a pulse that spans no rising edge, or only one, leaves the output unchanged.
- R5: The held value of an enabled line changes only at an edge where the level sampled at that edge matches the level sampled at the previous edge. Otherwise it keeps its previous value.
- R6: While the reset input is low, every enabled line outputs 0, the inactive level. This takes effect as soon as the reset input goes low, without waiting for a clock edge.
- R7: After the reset input goes high, the filter stays cleared for two debounce-clock rising edges. An enabled line with a steady active input first reads 1 just after the fourth rising edge following the release.
- R8: A low-active line uses the same two-sample filter on its inverted level. A pin held low across two edges gives an output of 1.
- R9: Lines are independent. A change on one line's pin, polarity or enable bit does not alter any other line's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| db_clk | input | 1 | Slow debounce clock, asynchronous to the bus clock |
| db_rst_n | input | 1 | Low-active reset. Clears immediately; released internally on db_clk edges |
| pin_in | input | WIDTH | Raw external input lines |
| pol_high | input | WIDTH | Per-line polarity: 1 means high-active or rising edge, 0 means low-active or falling edge |
| filt_en | input | WIDTH | Per-line enable: 1 selects the filtered level, 0 selects the bypass |
| cond_out | output | WIDTH | Conditioned, high-active level for each line |

## Verification
The hardest case to reach is on an enabled line whose held value disagrees with the pin. When the two samples disagree, the line must keep its held value, so the output still shows the older level while the pin shows the newer one. The stimulus table gets there in two ways. It applies one-edge pulses in both directions. It also uses a one-edge low dip after a line has settled high. Sub-period pulses are placed wholly between two rising edges. The reset is dropped in mid-cycle while the filters hold a 1, and the release is then counted edge by edge with an active input already present.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;

    // Per-line filter state: last sample and the level currently passed on
    typedef struct packed {
        logic samp;
        logic held;
    } lane_state_t;

    function automatic logic normalise(input logic raw, input pol_e pol);
        return (pol == POL_HIGH) ? raw : ~raw;
    endfunction

endpackage

// File: rtl/reset_release_sync.sv
module reset_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_sync_n
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/debounce_lane.sv
module debounce_lane
    import debounce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic pol_in,
    input  logic en_in,
    output logic norm_o,
    output logic held_o,
    output logic out_o
);
    lane_state_t st_d, st_q;
    logic        norm;

    always_comb begin
        norm = normalise(raw_in, pol_e'(pol_in));
        st_d = st_q;
        st_d.samp = norm;
        if (norm == st_q.samp) begin
            st_d.held = norm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign norm_o = norm;
    assign held_o = st_q.held;
    assign out_o  = en_in ? st_q.held : norm;

endmodule

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter #(
    parameter int WIDTH      = 8,
    parameter int RST_STAGES = 2
) (
    input  logic             db_clk,
    input  logic             db_rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] pol_high,
    input  logic [WIDTH-1:0] filt_en,
    output logic [WIDTH-1:0] cond_out
);
    logic             rst_sync_n;
    logic [WIDTH-1:0] norm_w;
    logic [WIDTH-1:0] held_w;

    reset_release_sync #(
        .STAGES(RST_STAGES)
    ) u_rst (
        .clk       (db_clk),
        .arst_n    (db_rst_n),
        .rst_sync_n(rst_sync_n)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        debounce_lane u_lane (
            .clk   (db_clk),
            .rst_n (rst_sync_n),
            .raw_in(pin_in[i]),
            .pol_in(pol_high[i]),
            .en_in (filt_en[i]),
            .norm_o(norm_w[i]),
            .held_o(held_w[i]),
            .out_o (cond_out[i])
        );
    end

endmodule

// File: rtl/pin_debounce_filter_chk.sv
module pin_debounce_filter_chk #(
    parameter int WIDTH = 8
) (
    input logic             db_clk,
    input logic             db_rst_n,
    input logic             rst_sync_n,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pol_high,
    input logic [WIDTH-1:0] filt_en,
    input logic [WIDTH-1:0] cond_out,
    input logic [WIDTH-1:0] norm_w,
    input logic [WIDTH-1:0] held_w
);
    // R1, R2: bypassed lines show the polarity-adjusted pin
    p_bypass_r2: assert property (@(posedge db_clk) disable iff (!db_rst_n)
        ((cond_out ^ (pin_in ~^ pol_high)) & ~filt_en) == '0);

    // R3, R4, R5: a held bit may change only to a level seen at two successive edges
    p_agree_r5: assert property (@(posedge db_clk) disable iff (!rst_sync_n)
        (((held_w ^ $past(held_w)) & (held_w ^ $past(norm_w))) == '0) &&
        (((held_w ^ $past(held_w)) & (held_w ^ $past(norm_w, 2))) == '0));

    // R6: reset forces enabled lines inactive
    p_reset_clear_r6: assert property (@(posedge db_clk)
        !db_rst_n |-> ((cond_out & filt_en) == '0));

    // R7: release of the filter clear lags the reset input
    p_late_release_r7: assert property (@(posedge db_clk) disable iff (!db_rst_n)
        $rose(db_rst_n) |=> !rst_sync_n);

endmodule

bind pin_debounce_filter pin_debounce_filter_chk #(.WIDTH(WIDTH)) u_chk (
    .db_clk    (db_clk),
    .db_rst_n  (db_rst_n),
    .rst_sync_n(rst_sync_n),
    .pin_in    (pin_in),
    .pol_high  (pol_high),
    .filt_en   (filt_en),
    .cond_out  (cond_out),
    .norm_w    (norm_w),
    .held_w    (held_w)
);

// File: tb/pin_debounce_filter_tb.sv
module pin_debounce_filter_tb;
    localparam int W = 4;
    localparam int NVEC = 14;

    // {pin[3:0], expected out[3:0]}; pol=0011, en=0101
    localparam logic [7:0] VEC [NVEC] = '{
        8'hC0, // idle, all inactive
        8'hD0, // bit0 one-edge pulse starts (R4)
        8'hC0, // one-edge pulse rejected (R4)
        8'hD0, // bit0 goes active, first edge
        8'hD1, // second edge: passes (R3)
        8'hF3, // bit1 bypass follows at once (R1 R2 R9)
        8'hB3, // bit2 low-active, first edge
        8'h3F, // bit2 passes (R8), bit3 bypass inverted (R1)
        8'h2F, // bit0 dip, samples disagree: hold (R5)
        8'h3F, // dip gone, still held (R4 R5)
        8'h2F, // bit0 low, first edge: held (R5)
        8'h2E, // bit0 low passes (R3)
        8'hC4, // bypass bits drop at once, bit2 held (R2 R5)
        8'hC0  // bit2 low passes (R3 R8)
    };

    logic         db_clk = 1'b0;
    logic         db_rst_n;
    logic [W-1:0] pin_in;
    logic [W-1:0] pol_high;
    logic [W-1:0] filt_en;
    logic [W-1:0] cond_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 db_clk = ~db_clk;

    pin_debounce_filter #(
        .WIDTH     (W),
        .RST_STAGES(2)
    ) u_dut (
        .db_clk  (db_clk),
        .db_rst_n(db_rst_n),
        .pin_in  (pin_in),
        .pol_high(pol_high),
        .filt_en (filt_en),
        .cond_out(cond_out)
    );

    task automatic check(input logic [W-1:0] exp, input string req);
        total++;
        if (cond_out !== exp) begin
            bad++;
            $display("FAIL %s: cond_out=%b expected=%b at %0t", req, cond_out, exp, $time);
        end
    endtask

    task automatic edge_check(input logic [W-1:0] exp, input string req);
        @(posedge db_clk);
        #1;
        check(exp, req);
    endtask

    initial begin
        db_rst_n = 1'b0;
        pin_in   = 4'b1100;
        pol_high = 4'b0011;
        filt_en  = 4'b0101;
        #1;
        check(4'b0000, "R6 reset state");
        repeat (3) @(posedge db_clk);
        @(negedge db_clk);
        db_rst_n = 1'b1;
        repeat (4) @(posedge db_clk);

        for (int k = 0; k < NVEC; k++) begin
            @(negedge db_clk);
            pin_in = VEC[k][7:4];
            edge_check(VEC[k][3:0], $sformatf("table step %0d (R1 R2 R3 R4 R5 R8 R9)", k));
        end

        // R4: pulse shorter than a period, wholly between edges
        @(negedge db_clk);
        #1;
        pin_in = 4'b1111;
        #1;
        check(4'b0010, "R4 short pulse, bypass bit shows it (R2)");
        #1;
        pin_in = 4'b1100;
        edge_check(4'b0000, "R4 short pulse rejected, edge 1");
        edge_check(4'b0000, "R4 short pulse rejected, edge 2");

        // settle all lines active: norm=1111
        @(negedge db_clk);
        pin_in = 4'b0011;
        edge_check(4'b1010, "R3 first edge, filtered bits still 0");
        edge_check(4'b1111, "R3 R8 second edge, all active");

        // R6: mid-cycle reset clears enabled lines at once
        @(negedge db_clk);
        #2;
        db_rst_n = 1'b0;
        #1;
        check(4'b1010, "R6 asynchronous clear");
        repeat (2) @(posedge db_clk);

        // R7: release counted edge by edge with active input present
        @(negedge db_clk);
        db_rst_n = 1'b1;
        edge_check(4'b1010, "R7 release edge 1");
        edge_check(4'b1010, "R7 release edge 2");
        edge_check(4'b1010, "R7 release edge 3");
        edge_check(4'b1111, "R7 release edge 4");

        // R9: toggling enable of one line leaves others alone
        @(negedge db_clk);
        filt_en = 4'b0100;
        pin_in  = 4'b0010;
        #1;
        check(4'b1110, "R9 bit0 bypass shows its low pin, others unchanged");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule